// File: doc/BRIEF.md
# Two-Output Programmable Interrupt Controller

This block gathers a parameterised set of interrupt lines (64 by default) and presents them to a processor as two request outputs. One is the ordinary request, `irq_o`. The other is the fast request, `fiq_o`. Software configures the block through a simple 32-bit register bus with a write strobe and a combinational read port. Sources are grouped into banks of 32, and every per-source register has one 32-bit word per bank, placed 4 bytes apart.

Each source can be set as level-sensitive or edge-triggered, and as active-high or active-low. Edge events are held in a sticky latch until software clears them. Software can also raise any source by itself through a software-request register. A per-source enable gates each source. Enables can be written directly, or changed one bit at a time through write-one-to-set and write-one-to-clear words. A per-source route bit sends the source to either output. A two-bit master enable gates each output. A pending-number word returns the lowest-numbered source that is asking on the ordinary output. When no source is asking, it returns a value that software programs.

Top module: `intc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all configuration words, the enables, the software requests, the edge latches, the no-pending value and the master enable are zero, and both outputs are low. All sources therefore start as level, active-high, routed to the ordinary output and disabled.
- R2: Source n is controlled by bit n%32 of the word at group base + 4*(n/32). The bus address is 12 bits, and only word-aligned addresses below 0x100 are decoded.
- R3: The enable words at 0x10 read back what was written. Writing to 0x30 sets every enable bit that is 1 in the data. Writing to 0x20 clears every enable bit that is 1 in the data. Zero bits written to 0x20 or 0x30 leave enables unchanged, and reads of 0x20 and 0x30 return zero.
- R4: A source whose type bit (group 0x40) is 0 is level-sensitive. When its polarity bit (group 0x50) is 0, its raw status (group 0xA0) equals the input. When its polarity bit is 1, its raw status equals the inverted input. The raw status follows the input in the same cycle.
- R5: A source whose type bit is 1 sets a sticky latch on a rising input transition when its polarity bit is 0, and on a falling transition when its polarity bit is 1. The transition is found against the input value registered on the previous clock. The latch stays set after the input returns and is cleared by writing 1 to that bit of group 0xB0.
- R6: If a new qualifying edge arrives in the same cycle as a clear write for that source, the latch remains set.
- R7: The software request words (group 0xC0) are readable and writable, and each bit is ORed into the raw status of its source.
- R8: The route bit (group 0x00) sends a source to the ordinary output when it is 0 and to the fast output when it is 1. The ordinary status (group 0x80) is raw AND enable AND NOT route. The fast status (group 0x90) is raw AND enable AND route.
- R9: The master enable at 0x64 holds two bits: bit 0 gates the ordinary output and bit 1 gates the fast output. `irq_o` is high exactly when bit 0 is set and any ordinary status bit is set. `fiq_o` is high exactly when bit 1 is set and any fast status bit is set.
- R10: A read of 0xD0 returns the index of the lowest-numbered source with its ordinary status set. When no such source exists, it returns the no-pending value held at 0x60.
- R11: Reads of undecoded addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Ordinary interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume several things about the inputs. The source lines must already be synchronous to `clk`. At most one bus write happens per cycle. Reset must be held for at least two clock edges, so that the registered input copy and the edge latches hold known values before any past-value check is made. The bench drives the sources and the bus only on falling clock edges, and it holds reset for several cycles. It changes polarity bits only while the inputs are static, so no transition appears that the test does not expect.

// File: rtl/intc_pkg.sv
// Package: register group codes shared by the interrupt controller.
// Assumes group code = address bits [7:4], bank = address bits [3:2].
package intc_pkg;
    localparam int BANK_W = 32;
    typedef logic [3:0] grp_t;
    localparam grp_t G_ROUTE  = 4'h0;
    localparam grp_t G_EN     = 4'h1;
    localparam grp_t G_ENCLR  = 4'h2;
    localparam grp_t G_ENSET  = 4'h3;
    localparam grp_t G_TYPE   = 4'h4;
    localparam grp_t G_POL    = 4'h5;
    localparam grp_t G_MISC   = 4'h6;
    localparam grp_t G_IRQST  = 4'h8;
    localparam grp_t G_FIQST  = 4'h9;
    localparam grp_t G_RAW    = 4'hA;
    localparam grp_t G_ECLR   = 4'hB;
    localparam grp_t G_SOFT   = 4'hC;
    localparam grp_t G_PEND   = 4'hD;
endpackage

// File: rtl/intc_edge_det.sv
// Module: per-source trigger conditioning.
// Registers a copy of each input, finds qualifying edges and keeps them
// in a sticky latch. Produces the hardware part of raw status.
// Assumes src_in is already synchronous to clk.
module intc_edge_det #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] typ,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] raw_hw
);
    logic [N-1:0] src_q;
    logic [N-1:0] edge_q;
    logic [N-1:0] act_now;
    logic [N-1:0] act_prev;
    logic [N-1:0] ev;

    // Polarity-corrected current and previous levels, and edge events.
    always_comb begin
        act_now  = src_in ^ pol;
        act_prev = src_q ^ pol;
        ev       = typ & act_now & ~act_prev;
        raw_hw   = (typ & edge_q) | (~typ & act_now);
    end

    // Input copy and sticky edge latch; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            edge_q <= '0;
        end else begin
            src_q  <= src_in;
            edge_q <= (edge_q & ~clr_mask) | ev;
        end
    end

    // R5: a latched edge only goes away through a clear write
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(edge_q) & ~$past(clr_mask) & ~edge_q) == '0));

    // R6: every detected edge is present in the latch on the next cycle
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/intc_lowest.sv
// Module: lowest-index finder over a request vector.
// Purely combinational; idx is meaningful only when found is high.
module intc_lowest #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is the last one assigned.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_ctrl.sv
// Module: two-output programmable interrupt controller (top).
// Holds the configuration registers, decodes the register bus, combines
// status and drives irq_o / fiq_o. Assumes NUM_SRC is a multiple of 32
// and at most 128 (bank is taken from address bits [3:2]).
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int NBANK = NUM_SRC / BANK_W;
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] route_q, en_q, type_q, pol_q, soft_q;
    logic [31:0]        nopend_q;
    logic [1:0]         master_q;
    logic               hit;
    grp_t               grp;
    logic [1:0]         bsel;
    logic [NUM_SRC-1:0] clr_mask, raw_hw, raw, irq_st, fiq_st;
    logic               pend_found;
    logic [IDX_W-1:0]   pend_idx;

    // Address decode: aligned, inside the 256-byte window.
    always_comb begin
        hit  = (bus_addr[ADDR_W-1:8] == '0) && (bus_addr[1:0] == 2'b00);
        grp  = bus_addr[7:4];
        bsel = bus_addr[3:2];
    end

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q  <= '0;
            en_q     <= '0;
            type_q   <= '0;
            pol_q    <= '0;
            soft_q   <= '0;
            nopend_q <= '0;
            master_q <= '0;
        end else if (bus_wr && hit) begin
            for (int b = 0; b < NBANK; b++) begin
                if (int'(bsel) == b) begin
                    case (grp)
                        G_ROUTE: route_q[b*BANK_W +: BANK_W] <= bus_wdata;
                        G_EN:    en_q[b*BANK_W +: BANK_W]    <= bus_wdata;
                        G_ENCLR: en_q[b*BANK_W +: BANK_W]    <= en_q[b*BANK_W +: BANK_W] & ~bus_wdata;
                        G_ENSET: en_q[b*BANK_W +: BANK_W]    <= en_q[b*BANK_W +: BANK_W] | bus_wdata;
                        G_TYPE:  type_q[b*BANK_W +: BANK_W]  <= bus_wdata;
                        G_POL:   pol_q[b*BANK_W +: BANK_W]   <= bus_wdata;
                        G_SOFT:  soft_q[b*BANK_W +: BANK_W]  <= bus_wdata;
                        default: ;
                    endcase
                end
            end
            if (grp == G_MISC && bsel == 2'd0) nopend_q <= bus_wdata;
            if (grp == G_MISC && bsel == 2'd1) master_q <= bus_wdata[1:0];
        end
    end

    // Edge-clear strobe for the addressed bank.
    always_comb begin
        clr_mask = '0;
        if (bus_wr && hit && grp == G_ECLR) begin
            for (int b = 0; b < NBANK; b++) begin
                if (int'(bsel) == b) clr_mask[b*BANK_W +: BANK_W] = bus_wdata;
            end
        end
    end

    intc_edge_det #(.N(NUM_SRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .pol      (pol_q),
        .typ      (type_q),
        .clr_mask (clr_mask),
        .raw_hw   (raw_hw)
    );

    // Status combination and output gating.
    always_comb begin
        raw    = raw_hw | soft_q;
        irq_st = raw & en_q & ~route_q;
        fiq_st = raw & en_q & route_q;
        irq_o  = master_q[0] & (|irq_st);
        fiq_o  = master_q[1] & (|fiq_st);
    end

    intc_lowest #(.N(NUM_SRC), .IDX_W(IDX_W)) u_low (
        .vec   (irq_st),
        .found (pend_found),
        .idx   (pend_idx)
    );

    // Read mux; undecoded addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            for (int b = 0; b < NBANK; b++) begin
                if (int'(bsel) == b) begin
                    case (grp)
                        G_ROUTE: bus_rdata = route_q[b*BANK_W +: BANK_W];
                        G_EN:    bus_rdata = en_q[b*BANK_W +: BANK_W];
                        G_TYPE:  bus_rdata = type_q[b*BANK_W +: BANK_W];
                        G_POL:   bus_rdata = pol_q[b*BANK_W +: BANK_W];
                        G_IRQST: bus_rdata = irq_st[b*BANK_W +: BANK_W];
                        G_FIQST: bus_rdata = fiq_st[b*BANK_W +: BANK_W];
                        G_RAW:   bus_rdata = raw[b*BANK_W +: BANK_W];
                        G_SOFT:  bus_rdata = soft_q[b*BANK_W +: BANK_W];
                        default: ;
                    endcase
                end
            end
            if (grp == G_MISC && bsel == 2'd0) bus_rdata = nopend_q;
            if (grp == G_MISC && bsel == 2'd1) bus_rdata = {30'd0, master_q};
            if (grp == G_PEND && bsel == 2'd0)
                bus_rdata = pend_found ? {{(32-IDX_W){1'b0}}, pend_idx} : nopend_q;
        end
    end

    // R3: a clear-enable write on bank 0 leaves none of the written bits set
    a_r3_enclr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && grp == G_ENCLR && bsel == 2'd0)
        |=> ((en_q[BANK_W-1:0] & $past(bus_wdata)) == '0));

    // R8: no source is reported on both outputs at once
    a_r8_route_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_st & fiq_st) == '0));

    // R9: a request output is never high while its master bit is clear
    a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o |-> master_q[0]) and (fiq_o |-> master_q[1])));

    // R10: the pending index is set and nothing below it is set
    a_r10_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        pend_found |-> (irq_st[pend_idx]
            && ((irq_st & ((NUM_SRC'(1) << pend_idx) - NUM_SRC'(1))) == '0)));
endmodule

// File: tb/sim_intc_ctrl.sv
module sim_intc_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    int total = 0;
    int bad = 0;
    logic [31:0] d;

    always #2 clk = ~clk;

    intc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic setsrc(input logic [63:0] v);
        @(negedge clk);
        src_in = v;
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        foreach (u0.bus_rdata[i]) ; // no-op keeps loop syntax local
        for (int a = 0; a < 'hD4; a += 4) begin
            rd(12'(a), d);
            chk("R1 reset read", d, 32'h0);
        end
        chk("R1 irq_o", {31'd0, irq_o}, 32'd0);
        chk("R1 fiq_o", {31'd0, fiq_o}, 32'd0);

        // R2/R3: enable direct, set, clear per bank
        for (int b = 0; b < 2; b++) begin
            logic [11:0] o;
            o = 12'(4 * b);
            wr(12'h10 + o, 32'hA5A5_0F0F ^ 32'(b));
            rd(12'h10 + o, d); chk("R3 direct", d, 32'hA5A5_0F0F ^ 32'(b));
            wr(12'h30 + o, 32'h0000_F000);
            rd(12'h10 + o, d); chk("R3 w1s", d, (32'hA5A5_0F0F ^ 32'(b)) | 32'h0000_F000);
            wr(12'h20 + o, 32'hA000_0001);
            rd(12'h10 + o, d); chk("R3 w1c", d, ((32'hA5A5_0F0F ^ 32'(b)) | 32'h0000_F000) & ~32'hA000_0001);
            wr(12'h30 + o, 32'h0); wr(12'h20 + o, 32'h0);
            rd(12'h10 + o, d); chk("R3 zero bits", d, ((32'hA5A5_0F0F ^ 32'(b)) | 32'h0000_F000) & ~32'hA000_0001);
            rd(12'h20 + o, d); chk("R3 clr reads 0", d, 32'h0);
            rd(12'h30 + o, d); chk("R3 set reads 0", d, 32'h0);
        end
        rd(12'h10, d); chk("R2 bank0 independent", d, 32'h05A5_FF0E);

        // Common setup
        wr(12'h10, 32'hFFFF_FFFF); wr(12'h14, 32'hFFFF_FFFF);
        wr(12'h60, 32'hDEAD_BEEF); rd(12'h60, d); chk("R10 nopend rw", d, 32'hDEAD_BEEF);
        wr(12'h64, 32'h1); rd(12'h64, d); chk("R9 master rw", d, 32'h1);

        // R2/R4/R10/R9: level, active-high sweep over every source
        for (int n = 0; n < 64; n++) begin
            setsrc(64'(1) << n);
            rd(12'hA0 + 12'(4 * (n / 32)), d);
            chk("R2 R4 raw level", d, 32'(1) << (n % 32));
            rd(12'hD0, d); chk("R10 pending", d, 32'(n));
            chk("R9 irq_o", {31'd0, irq_o}, 32'd1);
        end
        setsrc('0);
        rd(12'hD0, d); chk("R10 none pending", d, 32'hDEAD_BEEF);
        chk("R9 irq_o idle", {31'd0, irq_o}, 32'd0);

        // R4: active-low level
        wr(12'h50, 32'hFFFF_FFFF);
        rd(12'hA0, d); chk("R4 active-low idle", d, 32'hFFFF_FFFF);
        setsrc(64'h20);
        rd(12'hA0, d); chk("R4 active-low bit5", d, ~32'h20);
        setsrc('0);
        wr(12'h50, 32'h0);

        // R5: rising edges latched and cleared, every source
        wr(12'h40, 32'hFFFF_FFFF); wr(12'h44, 32'hFFFF_FFFF);
        for (int n = 0; n < 64; n++) begin
            logic [11:0] o;
            o = 12'(4 * (n / 32));
            setsrc(64'(1) << n);
            setsrc('0);
            rd(12'hA0 + o, d); chk("R5 edge held", d, 32'(1) << (n % 32));
            wr(12'hB0 + o, 32'(1) << (n % 32));
            rd(12'hA0 + o, d); chk("R5 edge cleared", d, 32'h0);
        end
        // R5: falling edge with polarity 1
        wr(12'h50, 32'h0000_0200);
        setsrc(64'h200);
        rd(12'hA0, d); chk("R5 rise ignored when falling", d, 32'h0);
        setsrc('0);
        rd(12'hA0, d); chk("R5 falling edge", d, 32'h200);
        wr(12'hB0, 32'h200);
        wr(12'h50, 32'h0);
        rd(12'hA0, d); chk("R5 after clear", d, 32'h0);

        // R6: new edge coincides with clear
        setsrc(64'h8); setsrc('0);
        @(negedge clk);
        src_in = 64'h8; bus_addr = 12'hB0; bus_wdata = 32'h8; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(12'hA0, d); chk("R6 edge wins", d, 32'h8);
        setsrc('0); wr(12'hB0, 32'h8);
        rd(12'hA0, d); chk("R6 later clear", d, 32'h0);
        wr(12'h40, 32'h0); wr(12'h44, 32'h0);

        // R7: software request
        wr(12'hC4, 32'h80);
        rd(12'hC4, d); chk("R7 soft rw", d, 32'h80);
        rd(12'hA4, d); chk("R7 soft raw", d, 32'h80);
        rd(12'hD0, d); chk("R7 soft pending", d, 32'd39);
        wr(12'hC4, 32'h0);
        rd(12'hA4, d); chk("R7 soft removed", d, 32'h0);

        // R8/R9: routing and master gating
        wr(12'h04, 32'h8); wr(12'h64, 32'h3);
        setsrc(64'(1) << 35);
        rd(12'h94, d); chk("R8 fast status", d, 32'h8);
        rd(12'h84, d); chk("R8 ordinary status", d, 32'h0);
        rd(12'hD0, d); chk("R10 fast not pending", d, 32'hDEAD_BEEF);
        chk("R9 fiq_o on", {31'd0, fiq_o}, 32'd1);
        chk("R9 irq_o off", {31'd0, irq_o}, 32'd0);
        wr(12'h64, 32'h1);
        chk("R9 fiq_o gated", {31'd0, fiq_o}, 32'd0);
        setsrc(64'h8); wr(12'h64, 32'h2);
        rd(12'h80, d); chk("R8 ordinary bit3", d, 32'h8);
        chk("R9 irq_o gated", {31'd0, irq_o}, 32'd0);
        wr(12'h64, 32'h1); wr(12'h04, 32'h0);

        // R10: lowest index wins
        setsrc((64'(1) << 40) | (64'(1) << 10));
        rd(12'hD0, d); chk("R10 lowest", d, 32'd10);
        setsrc(64'(1) << 40);
        rd(12'hD0, d); chk("R10 single high", d, 32'd40);
        setsrc('0);

        // R11: undecoded addresses
        rd(12'h070, d); chk("R11 read 0x70", d, 32'h0);
        rd(12'h0E0, d); chk("R11 read 0xE0", d, 32'h0);
        rd(12'h102, d); chk("R11 read unaligned", d, 32'h0);
        wr(12'h110, 32'h0); wr(12'h070, 32'h0); wr(12'h012, 32'h0);
        rd(12'h10, d); chk("R11 write ignored", d, 32'hFFFF_FFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule